// File: doc/BRIEF.md
# Cascadable 16/32-bit Timer Pair

Two 16-bit timers, a low-word unit and a high-word unit, sit behind a small register read/write port. Each unit has a control register, a period register and a count register. It can run freely on the system clock, accumulate only while an external gate input is high, or count rising edges of an external clock input. A four-step prescaler sits in front of each count. When the count reaches its period, the unit wraps to zero and raises a sticky interrupt flag.

Setting the chain bit in the low-word control register turns the pair into one 32-bit timer. The low-word control fields then drive both halves, and a carry out of the low word advances the high word. The 32-bit period match is reported on the high-word flag, which is gated by the high-word interrupt enable. Software clears a flag by writing the control register with the flag bit at zero.

Top module: `tmr_pair`

## Requirements
- R1: After reset every register reads zero and both interrupt outputs are low.
- R2: Register addresses: 0 low control, 1 low period, 2 low count, 3 high control, 4 high period, 5 high count. Control bits: bit0 enable, bit1 clock source (1 = external edges), bit2 gate, bits4:3 prescale, bit5 chain (acts only in the low control), bit6 interrupt enable, bit7 flag. Written values read back unchanged.
- R3: In timer mode (source 0, gate 0) with prescale 00, the count advances by one on every clock edge, starting on the edge after the edge that writes enable = 1. A disabled unit holds its count.
- R4: Prescale codes 00/01/10/11 give one count per 1/8/64/256 source events. Clearing enable resets the prescaler, so after a new enable the first count falls a full ratio later.
- R5: Outside gated mode, a tick that finds count == period sets the count to zero and sets the flag. The flag stays set until software writes 0 to bit7. Each interrupt output is that unit's flag AND its interrupt enable.
- R6: A write to a count register loads the written value. If a count tick falls in the same cycle, the write takes priority.
- R7: With clock source 1, each rising edge of the external clock input passes through a two-flop synchronizer. The count changes on the third clock edge after the input rises. The gate bit has no effect in this mode.
- R8: In gated mode (source 0, gate 1), the count advances on each internal tick while the synchronized gate is high. The flag sets on the gate's falling edge and not on a period match.
- R9: With chain set, {high count, low count} forms a 32-bit counter that uses only the low control fields. The high control register's enable, source, gate and prescale fields are ignored.
- R10: With chain set, a 32-bit count equal to {high period, low period} on a tick wraps both words to zero and sets the high flag. The low flag stays clear and the low interrupt output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk | input | 1 | External count clock, asynchronous |
| gate_in | input | 1 | External gate level, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data, combinational |
| irq_lo | output | 1 | Low-word unit interrupt request |
| irq_hi | output | 1 | High-word unit interrupt request |

## Verification
The interesting collision is a software load of a count register in the same cycle that the running timer produces a tick. Both paths update the same register on one edge. The bench provokes the collision by writing the low count while the timer runs at divide-by-one, so that every cycle carries a tick. The bench judges the result by reading the low count one cycle later and expecting exactly the loaded value, then the loaded value plus one on the following cycle, which shows the load won and counting then resumed.

// File: rtl/tmr_pkg.sv
// Shared types and constants for the timer pair.
// Assumes an 8-bit control layout and at least 8-bit register data.
package tmr_pkg;

    localparam int PSC_W = 8;
    localparam int ADDR_W = 3;

    typedef struct packed {
        logic       flag;   // bit7
        logic       ie;     // bit6
        logic       chain;  // bit5
        logic [1:0] ps;     // bits4:3
        logic       gate;   // bit2
        logic       cs;     // bit1
        logic       en;     // bit0
    } tmr_ctrl_t;

    // Terminal value of the prescaler counter for each ratio code
    function automatic logic [PSC_W-1:0] psc_limit(input logic [1:0] ps);
        case (ps)
            2'b00:   psc_limit = PSC_W'(0);
            2'b01:   psc_limit = PSC_W'(7);
            2'b10:   psc_limit = PSC_W'(63);
            default: psc_limit = PSC_W'(255);
        endcase
    endfunction

endpackage

// File: rtl/tmr_sync_edge.sv
// Brings an asynchronous level into the clock domain through STAGES flops
// and reports its synchronized level and one-cycle rise/fall pulses.
// Assumes the input is held for at least two clocks per level.
module tmr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh_q;

    // Shift chain: STAGES synchronizer flops plus one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], d};
    end

    assign level = sh_q[STAGES-1];
    assign rise  = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall  = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/tmr_prescaler.sv
// Divides a stream of source events by 1, 8, 64 or 256 and emits a
// combinational tick on the event that completes each ratio.
// Assumes run low clears the divider state.
module tmr_prescaler #(
    parameter int PW = tmr_pkg::PSC_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       src_pulse,
    input  logic [1:0] ps,
    output logic       tick
);
    logic [PW-1:0] cnt_q;
    logic [PW-1:0] limit;

    assign limit = PW'(tmr_pkg::psc_limit(ps));
    assign tick  = run && src_pulse && (cnt_q == limit);

    // Event counter, cleared while stopped and on each completed ratio
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (src_pulse) cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/tmr_pair.sv
// Pair of 16-bit timers that can chain into one 32-bit timer.
// Index 0 is the low-word unit, index 1 the high-word unit.
// Assumes DW >= 8; read data is combinational from rd_addr.
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk,
    input  logic              gate_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic              irq_lo,
    output logic              irq_hi
);
    localparam int NT = 2;

    tmr_ctrl_t     ctrl_q [NT];
    logic [DW-1:0] per_q  [NT];
    logic [DW-1:0] cnt_q  [NT];

    logic [NT-1:0] run, gated, tick, match16, ld_cnt, fall_hit, set_flag;
    logic          chain, match32, wrap_lo, ext_rise, gate_lvl, gate_fall;
    logic          unused_ext;

    assign chain = ctrl_q[0].chain;

    tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .d(ext_clk),
        .level(unused_ext), .rise(ext_rise), .fall()
    );

    tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_gate_sync (
        .clk(clk), .rst_n(rst_n), .d(gate_in),
        .level(gate_lvl), .rise(), .fall(gate_fall)
    );

    for (genvar i = 0; i < NT; i++) begin : g_unit
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(3 * i);
        logic src_pulse;

        // The high unit is held off while the low unit governs a chain
        if (i == 0) begin : g_run_lo
            assign run[i] = ctrl_q[i].en;
        end else begin : g_run_hi
            assign run[i] = ctrl_q[i].en && !chain;
        end

        assign gated[i]    = !ctrl_q[i].cs && ctrl_q[i].gate;
        assign src_pulse   = ctrl_q[i].cs ? ext_rise : (ctrl_q[i].gate ? gate_lvl : 1'b1);
        assign match16[i]  = (cnt_q[i] == per_q[i]);
        assign ld_cnt[i]   = wr_en && (wr_addr == BASE + 2'd2);
        assign fall_hit[i] = run[i] && gated[i] && gate_fall;

        tmr_prescaler u_psc (
            .clk(clk), .rst_n(rst_n), .run(run[i]),
            .src_pulse(src_pulse), .ps(ctrl_q[i].ps), .tick(tick[i])
        );

        // Control register: software write, then hardware flag set prevails
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctrl_q[i] <= '0;
            end else begin
                if (wr_en && wr_addr == BASE) ctrl_q[i] <= tmr_ctrl_t'(wr_data[7:0]);
                if (set_flag[i])              ctrl_q[i].flag <= 1'b1;
            end
        end

        // Period register: plain software storage
        always_ff @(posedge clk) begin
            if (!rst_n)                                 per_q[i] <= '0;
            else if (wr_en && wr_addr == BASE + 2'd1)  per_q[i] <= wr_data;
        end
    end

    assign match32 = ({cnt_q[1], cnt_q[0]} == {per_q[1], per_q[0]});
    assign wrap_lo = chain ? match32 : match16[0];

    // Flag set sources: period match outside gated mode, or gate falling edge
    always_comb begin
        set_flag[0] = !chain && ((tick[0] && match16[0] && !gated[0]) || fall_hit[0]);
        if (chain)
            set_flag[1] = (tick[0] && match32 && !gated[0]) || fall_hit[0];
        else
            set_flag[1] = (tick[1] && match16[1] && !gated[1]) || fall_hit[1];
    end

    // Count registers: load has priority, then 16-bit or chained 32-bit step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q[0] <= '0;
            cnt_q[1] <= '0;
        end else begin
            if (ld_cnt[0])    cnt_q[0] <= wr_data;
            else if (tick[0]) cnt_q[0] <= wrap_lo ? '0 : cnt_q[0] + 1'b1;

            if (ld_cnt[1]) begin
                cnt_q[1] <= wr_data;
            end else if (chain) begin
                if (tick[0]) cnt_q[1] <= match32 ? '0 : cnt_q[1] + DW'(&cnt_q[0]);
            end else if (tick[1]) begin
                cnt_q[1] <= match16[1] ? '0 : cnt_q[1] + 1'b1;
            end
        end
    end

    // Register read multiplexer
    always_comb begin
        case (rd_addr)
            3'd0:    rd_data = DW'(ctrl_q[0]);
            3'd1:    rd_data = per_q[0];
            3'd2:    rd_data = cnt_q[0];
            3'd3:    rd_data = DW'(ctrl_q[1]);
            3'd4:    rd_data = per_q[1];
            3'd5:    rd_data = cnt_q[1];
            default: rd_data = '0;
        endcase
    end

    assign irq_lo = ctrl_q[0].flag && ctrl_q[0].ie && !chain;
    assign irq_hi = ctrl_q[1].flag && ctrl_q[1].ie;
endmodule

// File: rtl/tmr_pair_chk.sv
// Temporal checks on the timer pair, bound into every tmr_pair instance.
module tmr_pair_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [2:0]    wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          lo_en,
    input logic          lo_free,
    input logic          lo_chain,
    input logic          lo_flag,
    input logic [DW-1:0] cnt_lo,
    input logic [DW-1:0] cnt_hi
);
    logic wr_cnt_lo, wr_cnt_hi, wr_ctrl_lo;
    assign wr_cnt_lo  = wr_en && wr_addr == 3'd2;
    assign wr_cnt_hi  = wr_en && wr_addr == 3'd5;
    assign wr_ctrl_lo = wr_en && wr_addr == 3'd0;

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_lo |=> cnt_lo == $past(wr_data)); // R6

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!lo_en && !wr_cnt_lo) |=> $stable(cnt_lo)); // R3

    AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_free && !wr_cnt_lo) |=> (cnt_lo == DW'($past(cnt_lo) + 1) || cnt_lo == '0)); // R5

    AST_LO_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_chain && !lo_flag && !wr_ctrl_lo) |=> !lo_flag); // R10

    AST_HI_FOLLOWS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_chain && !lo_en && !wr_cnt_hi) |=> $stable(cnt_hi)); // R9
endmodule

bind tmr_pair tmr_pair_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lo_en(ctrl_q[0].en),
    .lo_free(ctrl_q[0].en && !ctrl_q[0].cs && !ctrl_q[0].gate && ctrl_q[0].ps == 2'b00),
    .lo_chain(ctrl_q[0].chain), .lo_flag(ctrl_q[0].flag),
    .cnt_lo(cnt_q[0]), .cnt_hi(cnt_q[1])
);

// File: tb/tmr_pair_tb.sv
module tmr_pair_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_clk = 1'b0, gate_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0, rd_addr = '0;
    logic [15:0] wr_data = '0, rd_data;
    logic        irq_lo, irq_hi;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    localparam int IRQ = 8; // pseudo selector: {irq_hi, irq_lo}

    typedef struct {
        int          sel;
        logic [15:0] exp;
        string       req;
    } item_t;
    item_t sb[$];
    event  mon_ev;

    always #10 clk = ~clk; // 50 MHz

    tmr_pair u_dut (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .gate_in(gate_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: queue the expected item, steer the read port, wake the monitor
    task automatic expect_val(input int sel, input logic [15:0] exp, input string req);
        item_t it;
        it.sel = sel; it.exp = exp; it.req = req;
        sb.push_back(it);
        rd_addr = (sel < IRQ) ? 3'(sel) : 3'd0;
        #1 ->mon_ev;
        #1;
    endtask

    // Monitor: pop expected item and compare against the design outputs
    initial begin
        forever begin
            item_t it;
            logic [15:0] act;
            @(mon_ev);
            it = sb.pop_front();
            act = (it.sel == IRQ) ? {14'd0, irq_hi, irq_lo} : rd_data;
            n_chk++;
            if (act !== it.exp) begin
                n_err++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        for (int a = 0; a < 6; a++) expect_val(a, 16'h0, "R1");
        expect_val(IRQ, 16'h0, "R1");

        // R2: readback of control and period fields
        wr(3'd3, 16'h0058);
        expect_val(3, 16'h0058, "R2");
        wr(3'd4, 16'hBEEF);
        expect_val(4, 16'hBEEF, "R2");
        wr(3'd3, 16'h0000);

        // R3/R5: timer mode, divide by 1, period 5
        wr(3'd1, 16'd5);
        wr(3'd0, 16'h0041);
        expect_val(2, 16'd0, "R3");
        idle(1); expect_val(2, 16'd1, "R3");
        idle(4); expect_val(2, 16'd5, "R5"); expect_val(IRQ, 16'd0, "R5");
        idle(1); expect_val(2, 16'd0, "R5"); expect_val(IRQ, 16'd1, "R5");
        idle(1); expect_val(2, 16'd1, "R5"); expect_val(IRQ, 16'd1, "R5");
        wr(3'd0, 16'h0040);
        expect_val(IRQ, 16'd0, "R5");
        expect_val(2, 16'd3, "R3");
        idle(5); expect_val(2, 16'd3, "R3");

        // R4: divide by 8, then prescaler clear on disable
        wr(3'd0, 16'h0000); wr(3'd2, 16'h0); wr(3'd1, 16'hFFFF);
        wr(3'd0, 16'h0009);
        idle(31); expect_val(2, 16'd3, "R4");
        idle(1);  expect_val(2, 16'd4, "R4");
        idle(3);
        wr(3'd0, 16'h0008);
        wr(3'd0, 16'h0009);
        idle(7); expect_val(2, 16'd4, "R4");
        idle(1); expect_val(2, 16'd5, "R4");

        // R4: divide by 64 and by 256
        wr(3'd0, 16'h0000); wr(3'd2, 16'h0);
        wr(3'd0, 16'h0011);
        idle(127); expect_val(2, 16'd1, "R4");
        idle(1);   expect_val(2, 16'd2, "R4");
        wr(3'd0, 16'h0000); wr(3'd2, 16'h0);
        wr(3'd0, 16'h0019);
        idle(511); expect_val(2, 16'd1, "R4");
        idle(1);   expect_val(2, 16'd2, "R4");

        // R6: load while stopped, and load colliding with a tick
        wr(3'd0, 16'h0000);
        wr(3'd2, 16'h1234);
        expect_val(2, 16'h1234, "R6");
        wr(3'd0, 16'h0001);
        idle(3);
        wr(3'd2, 16'h0100);
        expect_val(2, 16'h0100, "R6");
        idle(1); expect_val(2, 16'h0101, "R6");

        // R7: external edges, gate bit set but ignored
        wr(3'd0, 16'h0000); wr(3'd2, 16'h0);
        wr(3'd0, 16'h0007);
        @(negedge clk); ext_clk = 1'b1;
        idle(2); expect_val(2, 16'd0, "R7");
        idle(1); expect_val(2, 16'd1, "R7");
        ext_clk = 1'b0;
        idle(3);
        for (int p = 0; p < 4; p++) begin
            ext_clk = 1'b1; idle(2);
            ext_clk = 1'b0; idle(3);
        end
        idle(4); expect_val(2, 16'd5, "R7");

        // R8: gated accumulation and flag on gate fall
        wr(3'd0, 16'h0000); wr(3'd2, 16'h0);
        wr(3'd0, 16'h0045);
        idle(5); expect_val(2, 16'd0, "R8");
        @(negedge clk); gate_in = 1'b1;
        idle(10); expect_val(IRQ, 16'd0, "R8");
        gate_in = 1'b0;
        idle(3); expect_val(2, 16'd10, "R8"); expect_val(IRQ, 16'd1, "R8");

        // R9/R10: chained 32-bit, high control fields set but ignored
        wr(3'd0, 16'h0020);
        wr(3'd3, 16'h0059);
        wr(3'd4, 16'h0001); wr(3'd1, 16'h0002);
        wr(3'd5, 16'h0000); wr(3'd2, 16'hFFFE);
        wr(3'd0, 16'h0061);
        expect_val(2, 16'hFFFE, "R9");
        idle(1); expect_val(2, 16'hFFFF, "R9"); expect_val(5, 16'h0000, "R9");
        idle(1); expect_val(2, 16'h0000, "R9"); expect_val(5, 16'h0001, "R9");
        idle(2); expect_val(2, 16'h0002, "R10"); expect_val(IRQ, 16'd0, "R10");
        idle(1); expect_val(2, 16'h0000, "R10"); expect_val(5, 16'h0000, "R10");
        expect_val(IRQ, 16'd2, "R10");
        expect_val(0, 16'h0061, "R10");

        // R5: high unit alone in 16-bit mode
        wr(3'd0, 16'h0000);
        wr(3'd3, 16'h0040);
        wr(3'd5, 16'h0000); wr(3'd4, 16'h0002);
        wr(3'd3, 16'h0041);
        idle(3); expect_val(5, 16'h0000, "R5"); expect_val(IRQ, 16'd2, "R5");

        idle(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule